// File: doc/BRIEF.md
# Event Channel with Edge Detection

This block is one channel of a peripheral event router. A generator drives a single event line into it, and the channel hands events on to a group of user peripherals. A two-bit path select chooses one of three routes:

- an asynchronous pass-through that needs no clock;
- a synchronous route, for a generator that runs on the channel's own clock;
- a resynchronized route, for a generator on a foreign clock. On this route the channel brings the line into its own clock domain before it detects edges.

On both clocked routes an edge selector picks rising edges, falling edges or both. Each detected edge becomes a pulse of one cycle on `evt_out`.

Toward the users, `evt_out` works as a valid strobe and `user_rdy` as the matching ready. The channel never stalls. A pulse is launched whether or not the enabled users are ready, and a user that is not ready, or an event still waiting for acknowledgement, is recorded in a sticky overrun flag. Users return `user_ack` to retire an event. On the resynchronized route, `busy` shows that acknowledgements are still outstanding. A sticky event-detected flag, write-one-to-clear inputs and an interrupt output complete the status.

Top module: `evt_channel`

## Requirements
- R1: `mode_sel` encodes the route: 0 and 3 select the asynchronous route, 1 selects the synchronous route and 2 selects the resynchronized route.
- R2: On the asynchronous route, `evt_out` follows `gen_evt` combinationally. Neither flag sets, `flag_ovr` reads 0 and `busy` stays low.
- R3: On the synchronous route, an edge on `gen_evt` that is sampled at clock edge k makes `evt_out` high in the cycle after edge k.
- R4: On the resynchronized route, an edge on `gen_evt` that is first sampled at clock edge k makes `evt_out` high in the cycle after edge k+2.
- R5: `edge_sel` selects the edges that count: 1 rising only, 2 falling only, 3 both, and 0 none.
- R6: Every detected edge gives exactly one cycle of `evt_out`. Edges on consecutive clock edges give back-to-back pulses.
- R7: `flag_evd` sets at the clock edge that launches a pulse and stays set until it is cleared.
- R8: `flag_ovr` sets at the clock edge that launches a pulse if either of two conditions holds at that edge: an enabled user (`user_en` bit set) has `user_rdy` low, or a user still owes an acknowledgement for the previous event and is not acknowledging at that edge.
- R9: On the resynchronized route, `busy` is high from the pulse cycle until every user enabled at the launch edge has returned `user_ack`, with acknowledgements sampled at clock edges. `busy` is low on the other routes.
- R10: A high `clr_evd` or `clr_ovr` at a clock edge clears that flag. If the flag is set at the same edge, the set wins.
- R11: `irq` is high when (`flag_evd` and `ie_evd`) or (`flag_ovr` and `ie_ovr`).
- R12: After a synchronous reset, `evt_out` on the clocked routes, `busy`, both flags and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Channel clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_sel | input | 2 | Route select (R1) |
| edge_sel | input | 2 | Edge select (R5) |
| gen_evt | input | 1 | Event line from the generator |
| user_en | input | NUM_USERS | Users attached to this channel |
| user_rdy | input | NUM_USERS | Per-user ready |
| user_ack | input | NUM_USERS | Per-user acknowledge |
| evt_out | output | 1 | Event strobe to the users |
| busy | output | 1 | Acknowledgements outstanding (resynchronized route) |
| clr_evd | input | 1 | Write-one clear of the event-detected flag |
| clr_ovr | input | 1 | Write-one clear of the overrun flag |
| ie_evd | input | 1 | Interrupt enable for event-detected |
| ie_ovr | input | 1 | Interrupt enable for overrun |
| flag_evd | output | 1 | Sticky event-detected flag |
| flag_ovr | output | 1 | Sticky overrun flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the channel with NUM_USERS = 3 and SYNC_STAGES = 2. Three users are enough to give masks that enable only part of the group, where one enabled user is not ready while a disabled one is ignored. They also allow partial acknowledgement, where `busy` must stay high until the last enabled user answers. The two-stage synchronizer makes the resynchronized latency exactly three clock edges, so the bench can check that latency cycle by cycle. Random phases on every route then compare all outputs each clock against a queue-based model.

// File: rtl/evt_chan_pkg.sv
package evt_chan_pkg;
  typedef enum logic [1:0] {
    PATH_ASYNC     = 2'd0,
    PATH_SYNC      = 2'd1,
    PATH_RESYNC    = 2'd2,
    PATH_ASYNC_ALT = 2'd3
  } path_e;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_BOTH = 2'd3
  } edge_e;

  localparam int FLAG_EVD  = 0;
  localparam int FLAG_OVR  = 1;
  localparam int NUM_FLAGS = 2;

  function automatic logic is_clocked(input logic [1:0] m);
    return (m == PATH_SYNC) || (m == PATH_RESYNC);
  endfunction
endpackage

// File: rtl/evt_sync.sv
module evt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/evt_edge_det.sv
module evt_edge_det (
  input  logic clk,
  input  logic rst,
  input  logic src,
  input  logic enable,
  input  logic rise_en,
  input  logic fall_en,
  output logic det
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= src;
  end

  assign det = enable & ((rise_en & src & ~prev_q) | (fall_en & ~src & prev_q));
endmodule

// File: rtl/evt_user_track.sv
module evt_user_track #(
  parameter int NUM_USERS = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clocked,
  input  logic                 launch,
  input  logic [NUM_USERS-1:0] user_en,
  input  logic [NUM_USERS-1:0] user_rdy,
  input  logic [NUM_USERS-1:0] user_ack,
  output logic                 pend_any,
  output logic                 ovr_hit
);
  logic [NUM_USERS-1:0] pend_q;
  logic [NUM_USERS-1:0] not_ready;
  logic [NUM_USERS-1:0] still_owed;

  always_ff @(posedge clk) begin
    if (rst)           pend_q <= '0;
    else if (!clocked) pend_q <= '0;
    else if (launch)   pend_q <= user_en;
    else               pend_q <= pend_q & ~user_ack;
  end

  assign not_ready  = user_en & ~user_rdy;
  assign still_owed = pend_q & ~user_ack;
  assign ovr_hit    = launch & ((|not_ready) | (|still_owed));
  assign pend_any   = |pend_q;
endmodule

// File: rtl/evt_flag_bank.sv
module evt_flag_bank #(
  parameter int NUM_FLAGS = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_FLAGS-1:0] set,
  input  logic [NUM_FLAGS-1:0] clr,
  input  logic [NUM_FLAGS-1:0] vis,
  input  logic [NUM_FLAGS-1:0] ie,
  output logic [NUM_FLAGS-1:0] flags,
  output logic                 irq
);
  logic [NUM_FLAGS-1:0] flag_q;

  generate
    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
      always_ff @(posedge clk) begin
        if (rst)         flag_q[i] <= 1'b0;
        else if (set[i]) flag_q[i] <= 1'b1;
        else if (clr[i]) flag_q[i] <= 1'b0;
      end
    end
  endgenerate

  assign flags = flag_q & vis;
  assign irq   = |(flags & ie);
endmodule

// File: rtl/evt_channel.sv
module evt_channel
  import evt_chan_pkg::*;
#(
  parameter int NUM_USERS   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [1:0]           mode_sel,
  input  logic [1:0]           edge_sel,
  input  logic                 gen_evt,
  input  logic [NUM_USERS-1:0] user_en,
  input  logic [NUM_USERS-1:0] user_rdy,
  input  logic [NUM_USERS-1:0] user_ack,
  output logic                 evt_out,
  output logic                 busy,
  input  logic                 clr_evd,
  input  logic                 clr_ovr,
  input  logic                 ie_evd,
  input  logic                 ie_ovr,
  output logic                 flag_evd,
  output logic                 flag_ovr,
  output logic                 irq
);
  path_e path;
  edge_e edge_mode;
  logic  clocked;
  logic  resynced;
  logic  src;
  logic  det;
  logic  evt_q;
  logic  pend_any;
  logic  ovr_hit;
  logic [NUM_FLAGS-1:0] f_set, f_clr, f_vis, f_ie, f_out;

  assign path      = path_e'(mode_sel);
  assign edge_mode = edge_e'(edge_sel);
  assign clocked   = is_clocked(mode_sel);
  assign resynced  = (path == PATH_RESYNC);

  evt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(gen_evt), .q(resync_line)
  );
  logic resync_line;

  assign src = resynced ? resync_line : gen_evt;

  evt_edge_det u_edge (
    .clk(clk), .rst(rst), .src(src), .enable(clocked),
    .rise_en(edge_mode == EDGE_RISE || edge_mode == EDGE_BOTH),
    .fall_en(edge_mode == EDGE_FALL || edge_mode == EDGE_BOTH),
    .det(det)
  );

  always_ff @(posedge clk) begin
    if (rst) evt_q <= 1'b0;
    else     evt_q <= det;
  end

  assign evt_out = clocked ? evt_q : gen_evt;

  evt_user_track #(.NUM_USERS(NUM_USERS)) u_track (
    .clk(clk), .rst(rst), .clocked(clocked), .launch(det),
    .user_en(user_en), .user_rdy(user_rdy), .user_ack(user_ack),
    .pend_any(pend_any), .ovr_hit(ovr_hit)
  );

  assign busy = resynced & pend_any;

  always_comb begin
    f_set           = '0;
    f_clr           = '0;
    f_vis           = '1;
    f_ie            = '0;
    f_set[FLAG_EVD] = det;
    f_set[FLAG_OVR] = ovr_hit;
    f_clr[FLAG_EVD] = clr_evd;
    f_clr[FLAG_OVR] = clr_ovr;
    f_vis[FLAG_OVR] = clocked;
    f_ie[FLAG_EVD]  = ie_evd;
    f_ie[FLAG_OVR]  = ie_ovr;
  end

  evt_flag_bank #(.NUM_FLAGS(NUM_FLAGS)) u_flags (
    .clk(clk), .rst(rst), .set(f_set), .clr(f_clr), .vis(f_vis),
    .ie(f_ie), .flags(f_out), .irq(irq)
  );

  assign flag_evd = f_out[FLAG_EVD];
  assign flag_ovr = f_out[FLAG_OVR];
endmodule

// File: rtl/evt_channel_chk.sv
module evt_channel_chk #(
  parameter int NUM_USERS = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic [1:0]           mode_sel,
  input logic [NUM_USERS-1:0] user_en,
  input logic                 evt_out,
  input logic                 busy,
  input logic                 clr_ovr,
  input logic                 ie_evd,
  input logic                 flag_evd,
  input logic                 flag_ovr,
  input logic                 irq
);
  // R7: a pulse on a clocked route that held its mode is seen with flag_evd set
  assert_evd_with_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    ((mode_sel == 2'd1 || mode_sel == 2'd2) && $stable(mode_sel) && evt_out) |-> flag_evd);

  // R9: resynchronized pulse toward a non-empty user mask raises busy
  assert_busy_on_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    (mode_sel == 2'd2 && $stable(mode_sel) && evt_out && $past(|user_en)) |-> busy);

  // R2: busy never shows on the asynchronous route
  assert_async_not_busy_R2: assert property (@(posedge clk) disable iff (rst)
    (mode_sel == 2'd0 || mode_sel == 2'd3) |-> !busy);

  // R10: overrun stays set unless cleared or hidden by the asynchronous route
  assert_ovr_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    (flag_ovr && !clr_ovr) |=> (flag_ovr || mode_sel == 2'd0 || mode_sel == 2'd3));

  // R11: an enabled event-detected flag raises the interrupt
  assert_irq_from_evd_R11: assert property (@(posedge clk) disable iff (rst)
    (flag_evd && ie_evd) |-> irq);
endmodule

bind evt_channel evt_channel_chk #(.NUM_USERS(NUM_USERS)) i_chk (
  .clk(clk), .rst(rst), .mode_sel(mode_sel), .user_en(user_en),
  .evt_out(evt_out), .busy(busy), .clr_ovr(clr_ovr), .ie_evd(ie_evd),
  .flag_evd(flag_evd), .flag_ovr(flag_ovr), .irq(irq)
);

// File: tb/test_evt_channel.sv
module test_evt_channel;
  localparam int PERIOD = 10;
  localparam int NU     = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    mode_sel = 2'd1;
  logic [1:0]    edge_sel = 2'd1;
  logic          gen_evt = 1'b0;
  logic [NU-1:0] user_en = '1;
  logic [NU-1:0] user_rdy = '1;
  logic [NU-1:0] user_ack = '0;
  logic          clr_evd = 1'b0, clr_ovr = 1'b0, ie_evd = 1'b0, ie_ovr = 1'b0;
  logic          evt_out, busy, flag_evd, flag_ovr, irq;

  int checks = 0;
  int fails = 0;
  int pulse_cnt = 0;
  bit cmp_en = 1'b0;
  bit done = 1'b0;

  // behavioural reference state
  bit          h[$];
  bit          m_evt, m_evd, m_ovr;
  bit [NU-1:0] m_pend;

  always #(PERIOD/2) clk = ~clk;

  evt_channel #(.NUM_USERS(NU), .SYNC_STAGES(2)) i_evt_channel (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .edge_sel(edge_sel),
    .gen_evt(gen_evt), .user_en(user_en), .user_rdy(user_rdy),
    .user_ack(user_ack), .evt_out(evt_out), .busy(busy),
    .clr_evd(clr_evd), .clr_ovr(clr_ovr), .ie_evd(ie_evd), .ie_ovr(ie_ovr),
    .flag_evd(flag_evd), .flag_ovr(flag_ovr), .irq(irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit clk_mode(input logic [1:0] m);
    return (m == 2'd1) || (m == 2'd2);
  endfunction

  initial begin
    h = '{1'b0, 1'b0, 1'b0};
    m_evt = 0; m_evd = 0; m_ovr = 0; m_pend = '0;
  end

  // reference model advances on every clock edge
  always @(posedge clk) begin
    bit cur, old, det, oc, cm;
    if (rst) begin
      m_evt = 0; m_evd = 0; m_ovr = 0; m_pend = '0;
      h = '{1'b0, 1'b0, 1'b0};
    end else begin
      cm = clk_mode(mode_sel);
      if (mode_sel == 2'd2) begin cur = h[1]; old = h[2]; end
      else begin cur = gen_evt; old = h[0]; end
      det = cm && ((edge_sel[0] && cur && !old) || (edge_sel[1] && !cur && old));
      oc  = (|(user_en & ~user_rdy)) || (|(m_pend & ~user_ack));
      m_evd = det || (m_evd && !clr_evd);
      m_ovr = (det && oc) || (m_ovr && !clr_ovr);
      m_pend = !cm ? '0 : (det ? user_en : (m_pend & ~user_ack));
      m_evt = det;
      h.push_front(gen_evt);
      void'(h.pop_back());
    end
  end

  // compare all outputs away from the active edge
  always @(negedge clk) begin
    bit cm, e_evt, e_ovr, e_busy, e_irq;
    string et;
    if (cmp_en) begin
      cm     = clk_mode(mode_sel);
      e_evt  = cm ? m_evt : gen_evt;
      e_ovr  = m_ovr && cm;
      e_busy = (mode_sel == 2'd2) && (|m_pend);
      e_irq  = (m_evd && ie_evd) || (e_ovr && ie_ovr);
      case (mode_sel)
        2'd0: et = "R2 evt_out";
        2'd1: et = "R3 evt_out";
        2'd2: et = "R4 evt_out";
        default: et = "R1 evt_out";
      endcase
      if (rst) et = "R12 evt_out";
      chk(et, evt_out, e_evt);
      chk(rst ? "R12 busy" : "R9 busy", busy, e_busy);
      chk(rst ? "R12 flag_evd" : "R7 flag_evd", flag_evd, m_evd);
      chk(rst ? "R12 flag_ovr" : "R8 flag_ovr", flag_ovr, e_ovr);
      chk(rst ? "R12 irq" : "R11 irq", irq, e_irq);
    end
    if (evt_out) pulse_cnt++;
  end

  task automatic tick(input int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic restart(input logic [1:0] m, input logic [1:0] es);
    rst = 1'b1; mode_sel = m; edge_sel = es; gen_evt = 1'b0;
    clr_evd = 0; clr_ovr = 0; ie_evd = 0; ie_ovr = 0;
    user_en = '1; user_rdy = '1; user_ack = '0;
    tick(2);
    rst = 1'b0;
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R12 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    restart(2'd1, 2'd1);
    cmp_en = 1'b1;
    // R12: reset state
    chk("R12 reset evt_out", evt_out, 0);
    chk("R12 reset flags", {flag_evd, flag_ovr, busy, irq}, 0);

    // R3: one-cycle latency, single pulse
    gen_evt = 1; tick(1);
    chk("R3 sync latency", evt_out, 1);
    tick(1);
    chk("R6 single cycle pulse", evt_out, 0);

    // R4: resynchronized latency of three edges
    restart(2'd2, 2'd1);
    gen_evt = 1; tick(1);
    chk("R4 not yet (1)", evt_out, 0);
    tick(1);
    chk("R4 not yet (2)", evt_out, 0);
    tick(1);
    chk("R4 resync latency", evt_out, 1);
    tick(1);
    chk("R4 pulse ends", evt_out, 0);

    // R5: edge selection
    for (int es = 0; es < 4; es++) begin
      restart(2'd1, es[1:0]);
      pulse_cnt = 0;
      for (int t = 0; t < 4; t++) begin gen_evt = ~gen_evt; tick(3); end
      tick(4);
      chk("R5 edge select count", pulse_cnt, (es == 0) ? 0 : (es == 3) ? 4 : 2);
    end

    // R6: back-to-back edges give back-to-back pulses
    restart(2'd1, 2'd3);
    pulse_cnt = 0;
    repeat (6) begin gen_evt = ~gen_evt; tick(1); end
    tick(3);
    chk("R6 back-to-back count", pulse_cnt, 6);

    // R2 / R1: asynchronous pass-through
    restart(2'd0, 2'd3);
    gen_evt = 1; #1;
    chk("R2 async follows", evt_out, 1);
    tick(3);
    chk("R2 async no flags", {flag_evd, flag_ovr, busy}, 0);
    gen_evt = 0; #1;
    chk("R2 async low", evt_out, 0);
    restart(2'd3, 2'd3);
    gen_evt = 1; #1;
    chk("R1 code 3 is async", evt_out, 1);

    // R8: enabled user not ready; disabled user ignored
    restart(2'd2, 2'd1);
    user_en = 3'b011; user_rdy = 3'b011 & 3'b101;
    gen_evt = 1; tick(4);
    chk("R8 overrun not ready", flag_ovr, 1);
    restart(2'd2, 2'd1);
    user_en = 3'b011; user_rdy = 3'b011;
    gen_evt = 1; tick(4);
    chk("R8 disabled user ignored", flag_ovr, 0);

    // R8: previous event not acknowledged
    restart(2'd1, 2'd3);
    user_en = 3'b001;
    gen_evt = 1; tick(1);
    gen_evt = 0; tick(1);
    chk("R8 overrun unacked", flag_ovr, 1);
    restart(2'd1, 2'd1);
    user_en = 3'b011;
    gen_evt = 1; tick(1);
    user_ack = 3'b011; tick(1);
    user_ack = 3'b000; gen_evt = 0; tick(2);
    gen_evt = 1; tick(1);
    chk("R8 acked no overrun", flag_ovr, 0);

    // R9: busy until the last enabled user acknowledges
    restart(2'd2, 2'd1);
    user_en = 3'b110;
    gen_evt = 1; tick(3);
    chk("R9 busy on pulse", busy, 1);
    user_ack = 3'b010; tick(1);
    chk("R9 busy partial ack", busy, 1);
    user_ack = 3'b100; tick(1);
    chk("R9 busy released", busy, 0);
    user_ack = 3'b000;
    restart(2'd1, 2'd1);
    gen_evt = 1; tick(1);
    chk("R9 busy low in sync", busy, 0);

    // R10: set beats a simultaneous clear, clear works afterwards
    restart(2'd1, 2'd1);
    clr_evd = 1; gen_evt = 1; tick(1);
    chk("R10 set wins", flag_evd, 1);
    tick(1);
    chk("R10 clear", flag_evd, 0);
    clr_evd = 0;

    // R11 / R7: interrupt and sticky flag
    restart(2'd1, 2'd1);
    ie_evd = 1; gen_evt = 1; tick(1);
    chk("R11 irq set", irq, 1);
    ie_evd = 0; #1;
    chk("R11 irq masked", irq, 0);
    tick(5);
    chk("R7 flag sticky", flag_evd, 1);

    // random phases on every route
    for (int m = 0; m < 4; m++) begin
      restart(m[1:0], 2'($urandom_range(0, 3)));
      for (int c = 0; c < 1500; c++) begin
        if ($urandom_range(0, 3) == 0) gen_evt = ~gen_evt;
        user_en  = NU'($urandom);
        user_rdy = ($urandom_range(0, 7) == 0) ? NU'($urandom) : '1;
        user_ack = NU'($urandom);
        clr_evd  = ($urandom_range(0, 15) == 0);
        clr_ovr  = ($urandom_range(0, 15) == 0);
        ie_evd   = $urandom_range(0, 1) == 1;
        ie_ovr   = $urandom_range(0, 1) == 1;
        if (c % 300 == 0) edge_sel = 2'($urandom_range(0, 3));
        tick(1);
      end
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule